// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block turns the control pins that a DDR SDRAM samples on each rising clock edge into one decoded command. The pins are chip select, the row and column strobes, write enable, the clock-enable level seen on the previous and the current edge, the address bus and the bank-address bits. The block folds the clock-enable history and the auto-precharge address bit into the command code. As a result, the read and write variants with auto-precharge, single-bank and all-bank precharge, auto refresh, self-refresh entry, and power-down entry and exit each get their own code.

Each decoded command appears one clock after the pins are sampled. It is given as a 5-bit enumerated code and as a one-hot vector. The outputs also carry the addressed bank, an auto-precharge flag, an extended-mode-register flag and the mode-register op code. Pin combinations that no legal command uses raise an illegal flag. A memory model or protocol monitor uses the block as its front end. The array itself is not modelled here.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are: `cmd` = DESEL (0), `cmd_oh` = 1, `bank` = 0, `auto_pre` = 0, `mr_ext` = 0, `op_code` = 0, `illegal` = 0.
- R2: If clock enable is high on both cycles and `cs_n` is high, the result is DESEL (0) whatever the strobes, address and bank bits are. Bank, flags and op code are all zero.
- R3: Take clock enable high on both cycles and `cs_n` low, and write the strobes as {ras_n,cas_n,we_n}. The codes are: 000 mode register set MRS (2), 011 activate ACT (3), 101 read RD (4), 100 write WR (6), 010 precharge, 110 burst stop BST (10), 111 no-op NOP (1) and 001 refresh.
- R4: For a read or a write, `addr[10]` high gives RDA (5) or WRA (7) with `auto_pre` = 1. Low gives RD or WR with `auto_pre` = 0.
- R5: For a precharge, `addr[10]` low gives PRE (8) with `bank` = `ba`. High gives PREA (9) with `bank` = 0.
- R6: For a mode register set, `ba` = 0 selects the base register (`mr_ext` = 0) and `ba` = 1 selects the extended register (`mr_ext` = 1). In both cases `op_code` = `addr`. A `ba` of 2 or 3 decodes as ILLEGAL (16). `op_code` is zero for every other command.
- R7: `bank` carries `ba` for ACT, RD, RDA, WR, WRA and PRE, and is zero for every other command.
- R8: The refresh pattern with clock enable 1 then 1 is auto refresh AREF (11). With clock enable 1 then 0 it is self-refresh entry SREF (12).
- R9: Clock enable 1 then 0 with `cs_n` high, or with the NOP pattern, is power-down entry PDE (13).
- R10: Clock enable 0 then 1 is the exit code EXIT (14), whatever the other pins are.
- R11: Clock enable 0 on both cycles is HOLD (15), and every other pin is ignored.
- R12: Clock enable 1 then 0 with `cs_n` low and any pattern other than refresh or NOP is ILLEGAL (16) with `illegal` = 1. `illegal` is 0 for every legal code.
- R13: Every output reflects the pins sampled at the previous rising edge. `cmd_oh` has exactly one bit set, at the index equal to `cmd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke_prev | input | 1 | Clock enable sampled on the previous edge |
| cke | input | 1 | Clock enable sampled on this edge |
| addr | input | ADDR_W | Address bus; bit AP_BIT is the auto-precharge / all-bank bit |
| ba | input | BA_W | Bank address / mode register selector |
| cmd | output | 5 | Decoded command code |
| cmd_oh | output | 17 | One-hot form of the command code |
| bank | output | BA_W | Addressed bank |
| auto_pre | output | 1 | Read or write with auto-precharge |
| mr_ext | output | 1 | Mode register set targets the extended register |
| op_code | output | ADDR_W | Mode register op code |
| illegal | output | 1 | Pin combination matches no legal command |

## Verification
The key overlap is between a falling clock enable and a command pattern in the same cycle. The refresh pattern must become self-refresh entry rather than auto refresh, NOP or chip-select-high must become power-down entry, and any other pattern must be flagged illegal. A second overlap is a rising clock enable together with an active command: the exit code must win. Both overlaps are provoked by sweeping every combination of clock-enable history, chip select, strobe pattern, address bit 10 and bank bits, and then by seeded random traffic. Each output is compared one cycle later against a decode function written inside the bench.

// File: rtl/ddrcd_pkg.sv
package ddrcd_pkg;

  localparam int CMD_W    = 5;
  localparam int NUM_CMDS = 17;

  typedef enum logic [CMD_W-1:0] {
    CMD_DESEL   = 5'd0,
    CMD_NOP     = 5'd1,
    CMD_MRS     = 5'd2,
    CMD_ACT     = 5'd3,
    CMD_RD      = 5'd4,
    CMD_RDA     = 5'd5,
    CMD_WR      = 5'd6,
    CMD_WRA     = 5'd7,
    CMD_PRE     = 5'd8,
    CMD_PREA    = 5'd9,
    CMD_BST     = 5'd10,
    CMD_AREF    = 5'd11,
    CMD_SREF    = 5'd12,
    CMD_PDE     = 5'd13,
    CMD_EXIT    = 5'd14,
    CMD_HOLD    = 5'd15,
    CMD_ILLEGAL = 5'd16
  } ddr_cmd_e;

  // strobe pattern {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CLS_MRS = 3'b000,
    CLS_REF = 3'b001,
    CLS_PRE = 3'b010,
    CLS_ACT = 3'b011,
    CLS_WR  = 3'b100,
    CLS_RD  = 3'b101,
    CLS_BST = 3'b110,
    CLS_NOP = 3'b111
  } ddr_cls_e;

  // clock-enable history {previous, current}
  typedef enum logic [1:0] {
    PH_LOW  = 2'b00,
    PH_RISE = 2'b01,
    PH_FALL = 2'b10,
    PH_RUN  = 2'b11
  } cke_phase_e;

endpackage

// File: rtl/ddrcd_class.sv
module ddrcd_class
  import ddrcd_pkg::*;
(
  input  logic       cs_n_i,
  input  logic       ras_n_i,
  input  logic       cas_n_i,
  input  logic       we_n_i,
  input  logic       cke_prev_i,
  input  logic       cke_i,
  output cke_phase_e phase_o,
  output ddr_cls_e   cls_o,
  output logic       sel_o
);

  always_comb begin
    phase_o = cke_phase_e'({cke_prev_i, cke_i});
    cls_o   = ddr_cls_e'({ras_n_i, cas_n_i, we_n_i});
    sel_o   = ~cs_n_i;
  end

endmodule

// File: rtl/ddrcd_qualify.sv
module ddrcd_qualify
  import ddrcd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  cke_phase_e        phase_i,
  input  ddr_cls_e          cls_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  output ddr_cmd_e          cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic              auto_pre_o,
  output logic              mr_ext_o,
  output logic [ADDR_W-1:0] op_code_o,
  output logic              illegal_o
);

  localparam logic [BA_W-1:0] MR_BASE = BA_W'(0);
  localparam logic [BA_W-1:0] MR_EXT  = BA_W'(1);

  logic ap_bit;
  assign ap_bit = addr_i[AP_BIT];

  always_comb begin
    cmd_o      = CMD_ILLEGAL;
    bank_o     = '0;
    auto_pre_o = 1'b0;
    mr_ext_o   = 1'b0;
    op_code_o  = '0;
    unique case (phase_i)
      PH_LOW:  cmd_o = CMD_HOLD;
      PH_RISE: cmd_o = CMD_EXIT;
      PH_FALL: begin
        if (!sel_i || cls_i == CLS_NOP) cmd_o = CMD_PDE;
        else if (cls_i == CLS_REF)      cmd_o = CMD_SREF;
        else                            cmd_o = CMD_ILLEGAL;
      end
      default: begin
        if (!sel_i) begin
          cmd_o = CMD_DESEL;
        end else begin
          unique case (cls_i)
            CLS_MRS: begin
              if (ba_i == MR_BASE || ba_i == MR_EXT) begin
                cmd_o     = CMD_MRS;
                mr_ext_o  = (ba_i == MR_EXT);
                op_code_o = addr_i;
              end else begin
                cmd_o = CMD_ILLEGAL;
              end
            end
            CLS_REF: cmd_o = CMD_AREF;
            CLS_PRE: begin
              if (ap_bit) begin
                cmd_o = CMD_PREA;
              end else begin
                cmd_o  = CMD_PRE;
                bank_o = ba_i;
              end
            end
            CLS_ACT: begin
              cmd_o  = CMD_ACT;
              bank_o = ba_i;
            end
            CLS_WR: begin
              cmd_o      = ap_bit ? CMD_WRA : CMD_WR;
              auto_pre_o = ap_bit;
              bank_o     = ba_i;
            end
            CLS_RD: begin
              cmd_o      = ap_bit ? CMD_RDA : CMD_RD;
              auto_pre_o = ap_bit;
              bank_o     = ba_i;
            end
            CLS_BST: cmd_o = CMD_BST;
            default: cmd_o = CMD_NOP;
          endcase
        end
      end
    endcase
    illegal_o = (cmd_o == CMD_ILLEGAL);
  end

endmodule

// File: rtl/ddrcd_outreg.sv
module ddrcd_outreg
  import ddrcd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ddr_cmd_e            cmd_d,
  input  logic [BA_W-1:0]     bank_d,
  input  logic                auto_pre_d,
  input  logic                mr_ext_d,
  input  logic [ADDR_W-1:0]   op_code_d,
  input  logic                illegal_d,
  output ddr_cmd_e            cmd_q,
  output logic [NUM_CMDS-1:0] cmd_oh_q,
  output logic [BA_W-1:0]     bank_q,
  output logic                auto_pre_q,
  output logic                mr_ext_q,
  output logic [ADDR_W-1:0]   op_code_q,
  output logic                illegal_q
);

  logic [NUM_CMDS-1:0] oh_d;

  generate
    for (genvar gi = 0; gi < NUM_CMDS; gi++) begin : g_oh
      assign oh_d[gi] = (cmd_d == ddr_cmd_e'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= CMD_DESEL;
      cmd_oh_q   <= NUM_CMDS'(1);
      bank_q     <= '0;
      auto_pre_q <= 1'b0;
      mr_ext_q   <= 1'b0;
      op_code_q  <= '0;
      illegal_q  <= 1'b0;
    end else begin
      cmd_q      <= cmd_d;
      cmd_oh_q   <= oh_d;
      bank_q     <= bank_d;
      auto_pre_q <= auto_pre_d;
      mr_ext_q   <= mr_ext_d;
      op_code_q  <= op_code_d;
      illegal_q  <= illegal_d;
    end
  end

  AST_OH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd_oh_q) == 1); // R13

  AST_ILL_AGREES: assert property (@(posedge clk) disable iff (rst)
    illegal_q == cmd_oh_q[CMD_ILLEGAL]); // R12

endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddrcd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                cke_prev,
  input  logic                cke,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BA_W-1:0]     ba,
  output logic [CMD_W-1:0]    cmd,
  output logic [NUM_CMDS-1:0] cmd_oh,
  output logic [BA_W-1:0]     bank,
  output logic                auto_pre,
  output logic                mr_ext,
  output logic [ADDR_W-1:0]   op_code,
  output logic                illegal
);

  cke_phase_e        phase;
  ddr_cls_e          cls;
  logic              sel;
  ddr_cmd_e          cmd_c;
  logic [BA_W-1:0]   bank_c;
  logic              ap_c;
  logic              mrx_c;
  logic [ADDR_W-1:0] op_c;
  logic              ill_c;
  ddr_cmd_e          cmd_r;

  ddrcd_class u_class (
    .cs_n_i     (cs_n),
    .ras_n_i    (ras_n),
    .cas_n_i    (cas_n),
    .we_n_i     (we_n),
    .cke_prev_i (cke_prev),
    .cke_i      (cke),
    .phase_o    (phase),
    .cls_o      (cls),
    .sel_o      (sel)
  );

  ddrcd_qualify #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_qual (
    .phase_i    (phase),
    .cls_i      (cls),
    .sel_i      (sel),
    .addr_i     (addr),
    .ba_i       (ba),
    .cmd_o      (cmd_c),
    .bank_o     (bank_c),
    .auto_pre_o (ap_c),
    .mr_ext_o   (mrx_c),
    .op_code_o  (op_c),
    .illegal_o  (ill_c)
  );

  ddrcd_outreg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_oreg (
    .clk        (clk),
    .rst        (rst),
    .cmd_d      (cmd_c),
    .bank_d     (bank_c),
    .auto_pre_d (ap_c),
    .mr_ext_d   (mrx_c),
    .op_code_d  (op_c),
    .illegal_d  (ill_c),
    .cmd_q      (cmd_r),
    .cmd_oh_q   (cmd_oh),
    .bank_q     (bank),
    .auto_pre_q (auto_pre),
    .mr_ext_q   (mr_ext),
    .op_code_q  (op_code),
    .illegal_q  (illegal)
  );

  assign cmd = cmd_r;

  AST_CS_MASK: assert property (@(posedge clk) disable iff (rst)
    (cke_prev && cke && cs_n) |=> (cmd == CMD_DESEL && bank == '0)); // R2

  AST_EXIT_ANY: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && cke) |=> (cmd == CMD_EXIT)); // R10

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && !cke) |=> (cmd == CMD_HOLD && !illegal)); // R11

  AST_AP_RW: assert property (@(posedge clk) disable iff (rst)
    auto_pre |-> (cmd == CMD_RDA || cmd == CMD_WRA)); // R4

  AST_MREXT: assert property (@(posedge clk) disable iff (rst)
    mr_ext |-> (cmd == CMD_MRS)); // R6

  AST_FALL_BAD: assert property (@(posedge clk) disable iff (rst)
    (cke_prev && !cke && !cs_n && !(ras_n && cas_n && we_n)
     && !(!ras_n && !cas_n && we_n)) |=> illegal); // R12

  AST_SREF_IN: assert property (@(posedge clk) disable iff (rst)
    (cke_prev && !cke && !cs_n && !ras_n && !cas_n && we_n)
    |=> (cmd == CMD_SREF)); // R8

endmodule

// File: tb/test_ddr_cmd_decoder.sv
module test_ddr_cmd_decoder;
  import ddrcd_pkg::*;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int AP_BIT = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic cke_prev = 1'b1, cke = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [BA_W-1:0]   ba = '0;
  logic [CMD_W-1:0]    cmd;
  logic [NUM_CMDS-1:0] cmd_oh;
  logic [BA_W-1:0]     bank;
  logic                auto_pre, mr_ext, illegal;
  logic [ADDR_W-1:0]   op_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ddr_cmd_decoder #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) i_ddr_cmd_decoder (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke_prev(cke_prev), .cke(cke), .addr(addr), .ba(ba),
    .cmd(cmd), .cmd_oh(cmd_oh), .bank(bank), .auto_pre(auto_pre), .mr_ext(mr_ext),
    .op_code(op_code), .illegal(illegal)
  );

  typedef struct packed {
    logic [4:0]        c;
    logic [BA_W-1:0]   bk;
    logic              ap;
    logic              mx;
    logic [ADDR_W-1:0] op;
    logic              il;
  } exp_t;

  function automatic exp_t model(logic cp, logic ck, logic csn, logic [2:0] rcw,
                                 logic [ADDR_W-1:0] a, logic [BA_W-1:0] b);
    exp_t e;
    e = '0;
    if (!cp && !ck)      e.c = 5'd15;
    else if (!cp && ck)  e.c = 5'd14;
    else if (cp && !ck) begin
      if (csn || rcw == 3'b111) e.c = 5'd13;
      else if (rcw == 3'b001)   e.c = 5'd12;
      else                      e.c = 5'd16;
    end else if (csn) e.c = 5'd0;
    else begin
      case (rcw)
        3'b000: if (b < 2) begin e.c = 5'd2; e.mx = (b == 1); e.op = a; end
                else e.c = 5'd16;
        3'b001: e.c = 5'd11;
        3'b010: if (a[AP_BIT]) e.c = 5'd9; else begin e.c = 5'd8; e.bk = b; end
        3'b011: begin e.c = 5'd3; e.bk = b; end
        3'b100: begin e.c = a[AP_BIT] ? 5'd7 : 5'd6; e.ap = a[AP_BIT]; e.bk = b; end
        3'b101: begin e.c = a[AP_BIT] ? 5'd5 : 5'd4; e.ap = a[AP_BIT]; e.bk = b; end
        3'b110: e.c = 5'd10;
        default: e.c = 5'd1;
      endcase
    end
    e.il = (e.c == 5'd16);
    return e;
  endfunction

  function automatic string tag_of(logic [4:0] c);
    case (c)
      5'd0: return "R2";
      5'd2: return "R6";
      5'd5, 5'd7: return "R4";
      5'd8, 5'd9: return "R5";
      5'd11, 5'd12: return "R8";
      5'd13: return "R9";
      5'd14: return "R10";
      5'd15: return "R11";
      5'd16: return "R12";
      default: return "R3";
    endcase
  endfunction

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic cp, logic ck, logic csn, logic [2:0] rcw,
                       logic [ADDR_W-1:0] a, logic [BA_W-1:0] b);
    exp_t e;
    @(negedge clk);
    cke_prev = cp; cke = ck; cs_n = csn;
    {ras_n, cas_n, we_n} = rcw;
    addr = a; ba = b;
    e = model(cp, ck, csn, rcw, a, b);
    @(posedge clk);
    #1;
    cmp(tag_of(e.c), 64'({cmd, auto_pre, mr_ext, op_code, illegal}),
        64'({e.c, e.ap, e.mx, e.op, e.il}));
    cmp("R7", 64'(bank), 64'(e.bk));
    cmp("R13", 64'(cmd_oh), 64'(1) << e.c);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    cmp("R1", 64'({cmd, cmd_oh, bank, auto_pre, mr_ext, op_code, illegal}),
        64'({5'd0, 17'd1, 2'd0, 1'b0, 1'b0, 13'd0, 1'b0}));
    @(negedge clk);
    rst = 1'b0;
    // directed corners: refresh under each clock-enable history
    apply(1, 1, 0, 3'b001, 13'h0, 2'd0);
    apply(1, 0, 0, 3'b001, 13'h0, 2'd0);
    apply(0, 1, 0, 3'b001, 13'h0, 2'd0);
    apply(0, 0, 0, 3'b000, 13'h1fff, 2'd3);
    apply(1, 0, 1, 3'b000, 13'h0, 2'd0);
    apply(1, 1, 0, 3'b000, 13'h1abc, 2'd1);
    apply(1, 1, 0, 3'b000, 13'h0123, 2'd2);
    // exhaustive control sweep
    for (int cp = 0; cp < 2; cp++)
      for (int ck = 0; ck < 2; ck++)
        for (int cs = 0; cs < 2; cs++)
          for (int r = 0; r < 8; r++)
            for (int ap = 0; ap < 2; ap++)
              for (int b = 0; b < 4; b++) begin
                logic [ADDR_W-1:0] a;
                a = ADDR_W'($urandom);
                a[AP_BIT] = ap[0];
                apply(cp[0], ck[0], cs[0], r[2:0], a, b[1:0]);
              end
    // seeded random traffic, biased toward running clock enable
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] k;
      k = 4'($urandom);
      apply(k != 0, k != 1, ($urandom % 6) == 0, 3'($urandom),
            ADDR_W'($urandom), BA_W'($urandom));
    end
    // reset mid-stream returns to DESEL
    @(negedge clk);
    rst = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b011;
    @(posedge clk);
    #1;
    cmp("R1", 64'({cmd, cmd_oh, bank}), 64'({5'd0, 17'd1, 2'd0}));
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule